// File: doc/BRIEF.md
# CCM Authentication and Counter Sequencer

This block runs the whole CCM encryption of one packet around an external 128-bit block cipher. Software-side logic gives it the tag size, the length-field size, the nonce and the two byte counts in one start pulse. The block then takes the associated data and the plaintext as one byte stream, forms every block that CCM needs and sends each one to the cipher through a single request/acknowledge port. It returns the ciphertext bytes, then the encrypted tag, as an output byte stream. The last tag byte carries a last marker.

For authentication it chains CBC-MAC over the first block, the length-prefixed associated data and the message, with zero padding inside each of these groups. For confidentiality it encrypts counter blocks numbered from 1 and XORs the results onto the plaintext. The counter block numbered 0 is encrypted last, and only to mask the tag. Each cipher request carries a bit that says whether it is for the MAC chain or for the counter stream.

Top module: `ccm_seq`

## Requirements
- R1: After reset, and between packets, `cph_req`, `out_valid`, `out_last` and `in_ready` are all low.
- R2: The first cipher request of a packet is a MAC request (`cph_ctr`=0). Its octet 0 is a flags byte with bit 7 = 0, bit 6 = 1 exactly when the associated-data length is nonzero, bits 5:3 = `cfg_mfld` and bits 2:0 = `cfg_lfld`.
- R3: In that first block, octets 1 to 15-L hold nonce bytes taken from the most significant end of `cfg_nonce`, and octets 16-L to 15 hold the message length, most significant byte first. L = `cfg_lfld`+1, and octet 0 is bits 127:120.
- R4: A nonzero associated-data length a is preceded by a prefix. The prefix is 2 bytes holding a when a < 65280, bytes FF FE and then 4 bytes of a when a < 2^32, and otherwise bytes FF FF and then 8 bytes of a. Lengths are written most significant byte first.
- R5: The prefix with the associated data, and the message on its own, are each cut into 16-byte blocks, and each group's last block is zero padded. An empty message adds no block, and no block is ever all padding.
- R6: Each later MAC request carries the previous cipher result of the MAC chain XOR the next block. The tag T is the first M bytes of the final MAC result, where M = 2*`cfg_mfld`+2.
- R7: Counter requests (`cph_ctr`=1) carry a block whose flags byte is 5 zero bits followed by `cfg_lfld`, then the nonce, then the counter i in the last L octets, most significant byte first. One counter request is made for each message block, with i counting up from 1. After the last message block, a counter request for i = 0 is made.
- R8: The ciphertext bytes of message block i equal the plaintext bytes XOR the leading bytes of the result for counter i. Exactly the message length in bytes is output.
- R9: After the ciphertext, exactly M bytes T XOR S_0 are output, where S_0 is the result for counter 0. `out_last` is high on the final one only.
- R10: At most one cipher request is open at a time. The request, its block and its tag bit hold steady until `cph_ack`. Input bytes are accepted only while no request is open.
- R11: The configuration is captured on a start pulse accepted while idle. A start pulse, or a change of the cfg inputs, during a packet has no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (taken only when idle) |
| cfg_mfld | input | 3 | Tag size code (M-2)/2, valid 1..7 |
| cfg_lfld | input | 3 | Length-field size code L-1, valid 1..7 |
| cfg_nonce | input | 104 | Nonce, first byte in bits 103:96 |
| cfg_alen | input | ALEN_W | Associated-data length in bytes |
| cfg_mlen | input | MLEN_W | Message length in bytes |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Associated data, then plaintext |
| in_ready | output | 1 | Input byte accepted this cycle when in_valid |
| cph_req | output | 1 | Cipher request open |
| cph_ctr | output | 1 | 0 = MAC block, 1 = counter block |
| cph_blk | output | 128 | Block to encrypt |
| cph_ack | input | 1 | One-cycle completion strobe |
| cph_res | input | 128 | Cipher result, valid with cph_ack |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Ciphertext, then encrypted tag |
| out_last | output | 1 | Final tag byte |

## Verification
The checks assume that the cipher acknowledges only a request that is open, with one pulse per request. They also assume that the configuration is legal (M code 1..7, L code 1..7) and that the message length fits in L bytes. The stand-in cipher in the bench answers with a fixed delay and pulses `cph_ack` exactly once per request. Every packet uses legal codes and short messages, so these assumptions always hold. The associated-data lengths are chosen to reach the two-byte prefix, the six-byte prefix and a prefix-plus-data group that fills one block exactly.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
    localparam int BLK_W   = 128;
    localparam int NONCE_W = 104;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_AAD, ST_MSG, ST_MSGMAC, ST_EMIT, ST_TAG
    } state_e;

    function automatic logic [7:0] byte_at(input logic [BLK_W-1:0] v, input logic [4:0] k);
        int pos;
        pos = 15 - int'(k[3:0]);
        return v[pos*8 +: 8];
    endfunction

    function automatic logic [BLK_W-1:0] byte_put(input logic [BLK_W-1:0] v,
                                                    input logic [4:0] k,
                                                    input logic [7:0] b);
        logic [BLK_W-1:0] r;
        int pos;
        r = v;
        pos = 15 - int'(k[3:0]);
        r[pos*8 +: 8] = b;
        return r;
    endfunction
endpackage

// File: rtl/ccm_ctrblk.sv
// Formats a flags/nonce/counter block; the split point follows the L code.
module ccm_ctrblk (
    input  logic [7:0]   flags,
    input  logic [103:0] nonce,
    input  logic [2:0]   lfld,
    input  logic [63:0]  val,
    output logic [127:0] blk
);
    for (genvar k = 0; k < 16; k++) begin : g_oct
        if (k == 0) begin : g_flags
            assign blk[127:120] = flags;
        end else begin : g_body
            always_comb begin
                if (k <= 14 - int'(lfld)) begin
                    blk[8*(15-k) +: 8] = nonce[8*(13-k) +: 8];
                end else if (15 - k < 8) begin
                    blk[8*(15-k) +: 8] = val[8*(15-k) +: 8];
                end else begin
                    blk[8*(15-k) +: 8] = 8'h00;
                end
            end
        end
    end
endmodule

// File: rtl/ccm_aadpfx.sv
// Length prefix for associated data: picks its form and returns one byte.
module ccm_aadpfx #(
    parameter int ALEN_W = 32
) (
    input  logic [ALEN_W-1:0] alen,
    input  logic [3:0]        idx,
    output logic [3:0]        plen,
    output logic [7:0]        pbyte
);
    logic [63:0] a64;
    logic [79:0] pv;

    always_comb begin
        a64 = 64'(alen);
        if (a64 < 64'd65280) begin
            plen = 4'd2;
            pv   = {a64[15:0], 64'h0};
        end else if (a64 < 64'h1_0000_0000) begin
            plen = 4'd6;
            pv   = {16'hFFFE, a64[31:0], 32'h0};
        end else begin
            plen = 4'd10;
            pv   = {16'hFFFF, a64};
        end
        pbyte = (idx < 4'd10) ? pv[8*(9 - int'(idx)) +: 8] : 8'h00;
    end
endmodule

// File: rtl/ccm_seq.sv
module ccm_seq
    import ccm_pkg::*;
#(
    parameter int MLEN_W = 16,
    parameter int ALEN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cfg_mfld,
    input  logic [2:0]        cfg_lfld,
    input  logic [103:0]      cfg_nonce,
    input  logic [ALEN_W-1:0] cfg_alen,
    input  logic [MLEN_W-1:0] cfg_mlen,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              cph_req,
    output logic              cph_ctr,
    output logic [127:0]      cph_blk,
    input  logic              cph_ack,
    input  logic [127:0]      cph_res,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last
);
    localparam int RW = (ALEN_W > MLEN_W) ? ALEN_W : MLEN_W;

    typedef struct packed {
        state_e              state;
        state_e              ret;
        logic [2:0]          mfld;
        logic [2:0]          lfld;
        logic [NONCE_W-1:0]  nonce;
        logic [ALEN_W-1:0]   alen;
        logic [MLEN_W-1:0]   mlen;
        logic [BLK_W-1:0]    x;
        logic [BLK_W-1:0]    s;
        logic [BLK_W-1:0]    buff;
        logic [4:0]          cnt;
        logic [4:0]          eidx;
        logic [RW-1:0]       rem;
        logic [3:0]          pidx;
        logic [MLEN_W-1:0]   ctr;
        logic                req;
        logic                ctr_tag;
        logic [BLK_W-1:0]    blk;
        logic                ov;
        logic [7:0]          od;
        logic                ol;
    } st_t;

    st_t st_d, st_q;
    logic rdy;

    logic [7:0]   fmt_flags;
    logic [103:0] fmt_nonce;
    logic [2:0]   fmt_lfld;
    logic [63:0]  fmt_val;
    logic [127:0] fmt_blk;
    logic [3:0]   pfx_len;
    logic [7:0]   pfx_byte;
    logic         pfx_done;

    always_comb begin
        if (st_q.state == ST_IDLE) begin
            fmt_flags = {1'b0, cfg_alen != '0, cfg_mfld, cfg_lfld};
            fmt_nonce = cfg_nonce;
            fmt_lfld  = cfg_lfld;
            fmt_val   = 64'(cfg_mlen);
        end else begin
            fmt_flags = {5'b0, st_q.lfld};
            fmt_nonce = st_q.nonce;
            fmt_lfld  = st_q.lfld;
            fmt_val   = (st_q.rem == '0 && st_q.cnt == 5'd0) ? 64'd0
                                                             : 64'(st_q.ctr + 1'b1);
        end
    end

    ccm_ctrblk u_fmt (
        .flags (fmt_flags),
        .nonce (fmt_nonce),
        .lfld  (fmt_lfld),
        .val   (fmt_val),
        .blk   (fmt_blk)
    );

    ccm_aadpfx #(.ALEN_W(ALEN_W)) u_pfx (
        .alen  (st_q.alen),
        .idx   (st_q.pidx),
        .plen  (pfx_len),
        .pbyte (pfx_byte)
    );

    assign pfx_done = (st_q.pidx == pfx_len);

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.ol = 1'b0;
        rdy     = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.mfld    = cfg_mfld;
                    st_d.lfld    = cfg_lfld;
                    st_d.nonce   = cfg_nonce;
                    st_d.alen    = cfg_alen;
                    st_d.mlen    = cfg_mlen;
                    st_d.x       = '0;
                    st_d.buff    = '0;
                    st_d.cnt     = 5'd0;
                    st_d.pidx    = 4'd0;
                    st_d.ctr     = '0;
                    st_d.rem     = (cfg_alen != '0) ? RW'(cfg_alen) : RW'(cfg_mlen);
                    st_d.req     = 1'b1;
                    st_d.ctr_tag = 1'b0;
                    st_d.blk     = fmt_blk;
                    st_d.ret     = (cfg_alen != '0) ? ST_AAD : ST_MSG;
                    st_d.state   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cph_ack) begin
                    st_d.req = 1'b0;
                    if (st_q.ctr_tag) st_d.s = cph_res;
                    else              st_d.x = cph_res;
                    st_d.state = st_q.ret;
                end
            end
            ST_AAD: begin
                if (st_q.cnt == 5'd16 || (pfx_done && st_q.rem == '0 && st_q.cnt != 5'd0)) begin
                    st_d.req     = 1'b1;
                    st_d.ctr_tag = 1'b0;
                    st_d.blk     = st_q.x ^ st_q.buff;
                    st_d.buff    = '0;
                    st_d.cnt     = 5'd0;
                    st_d.ret     = ST_AAD;
                    st_d.state   = ST_WAIT;
                end else if (pfx_done && st_q.rem == '0) begin
                    st_d.rem   = RW'(st_q.mlen);
                    st_d.state = ST_MSG;
                end else if (!pfx_done) begin
                    st_d.buff = byte_put(st_q.buff, st_q.cnt, pfx_byte);
                    st_d.cnt  = st_q.cnt + 5'd1;
                    st_d.pidx = st_q.pidx + 4'd1;
                end else begin
                    rdy = 1'b1;
                    if (in_valid) begin
                        st_d.buff = byte_put(st_q.buff, st_q.cnt, in_data);
                        st_d.cnt  = st_q.cnt + 5'd1;
                        st_d.rem  = st_q.rem - RW'(1);
                    end
                end
            end
            ST_MSG: begin
                if (st_q.cnt == 5'd16 || (st_q.rem == '0 && st_q.cnt != 5'd0)) begin
                    st_d.ctr     = st_q.ctr + 1'b1;
                    st_d.req     = 1'b1;
                    st_d.ctr_tag = 1'b1;
                    st_d.blk     = fmt_blk;
                    st_d.ret     = ST_MSGMAC;
                    st_d.state   = ST_WAIT;
                end else if (st_q.rem == '0) begin
                    st_d.req     = 1'b1;
                    st_d.ctr_tag = 1'b1;
                    st_d.blk     = fmt_blk;
                    st_d.eidx    = 5'd0;
                    st_d.ret     = ST_TAG;
                    st_d.state   = ST_WAIT;
                end else begin
                    rdy = 1'b1;
                    if (in_valid) begin
                        st_d.buff = byte_put(st_q.buff, st_q.cnt, in_data);
                        st_d.cnt  = st_q.cnt + 5'd1;
                        st_d.rem  = st_q.rem - RW'(1);
                    end
                end
            end
            ST_MSGMAC: begin
                st_d.req     = 1'b1;
                st_d.ctr_tag = 1'b0;
                st_d.blk     = st_q.x ^ st_q.buff;
                st_d.eidx    = 5'd0;
                st_d.ret     = ST_EMIT;
                st_d.state   = ST_WAIT;
            end
            ST_EMIT: begin
                st_d.ov   = 1'b1;
                st_d.od   = byte_at(st_q.buff, st_q.eidx) ^ byte_at(st_q.s, st_q.eidx);
                st_d.eidx = st_q.eidx + 5'd1;
                if (st_q.eidx == st_q.cnt - 5'd1) begin
                    st_d.buff  = '0;
                    st_d.cnt   = 5'd0;
                    st_d.state = ST_MSG;
                end
            end
            ST_TAG: begin
                st_d.ov   = 1'b1;
                st_d.od   = byte_at(st_q.x, st_q.eidx) ^ byte_at(st_q.s, st_q.eidx);
                st_d.eidx = st_q.eidx + 5'd1;
                if (st_q.eidx == {1'b0, st_q.mfld, 1'b1}) begin
                    st_d.ol    = 1'b1;
                    st_d.state = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
            st_q.ret   <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = rdy;
    assign cph_req   = st_q.req;
    assign cph_ctr   = st_q.ctr_tag;
    assign cph_blk   = st_q.blk;
    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_last  = st_q.ol;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req && !cph_ack |=> cph_req && $stable(cph_blk) && $stable(cph_ctr));

    // R10
    no_io_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req |-> !in_ready && !out_valid);

    // R9
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state != ST_IDLE) |=> $stable(st_q.nonce) && $stable(st_q.mlen)
                                    && $stable(st_q.mfld) && $stable(st_q.lfld));

    // R5
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= 5'd16);
endmodule

// File: tb/tb_ccm_seq.sv
module tb_ccm_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   cfg_mfld = '0;
    logic [2:0]   cfg_lfld = '0;
    logic [103:0] cfg_nonce = '0;
    logic [31:0]  cfg_alen = '0;
    logic [15:0]  cfg_mlen = '0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = '0;
    logic         in_ready;
    logic         cph_req, cph_ctr;
    logic [127:0] cph_blk;
    logic         cph_ack = 1'b0;
    logic [127:0] cph_res = '0;
    logic         out_valid, out_last;
    logic [7:0]   out_data;

    always #2.5 clk = ~clk;

    ccm_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mfld(cfg_mfld), .cfg_lfld(cfg_lfld),
        .cfg_nonce(cfg_nonce), .cfg_alen(cfg_alen), .cfg_mlen(cfg_mlen),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .cph_req(cph_req), .cph_ctr(cph_ctr), .cph_blk(cph_blk),
        .cph_ack(cph_ack), .cph_res(cph_res),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    typedef struct {
        logic         tag;
        logic [127:0] blk;
        string        lbl;
    } rq_t;
    typedef struct {
        logic       last;
        logic [7:0] data;
        string      lbl;
    } ob_t;

    rq_t rq_q[$];
    ob_t ob_q[$];
    int  nchk = 0;
    int  nerr = 0;
    bit  pkt_done = 0;

    task automatic chk(input bit ok, input string msg, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", msg, act, exp);
        end
    endtask

    function automatic logic [127:0] stand_in(input logic [127:0] v);
        return ({v[90:0], v[127:91]} ^ 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0) + {v[63:0], v[127:64]};
    endfunction

    function automatic logic [127:0] mk_blk(input logic [7:0] fl, input logic [103:0] n,
                                            input int lb, input longint unsigned val);
        logic [127:0] r;
        r[127:120] = fl;
        for (int i = 1; i < 16; i++) begin
            if (i <= 15 - lb) r[127-8*i -: 8] = n[103-8*(i-1) -: 8];
            else              r[127-8*i -: 8] = 8'(val >> (8*(15-i)));
        end
        return r;
    endfunction

    // cipher stand-in plus request/output monitors, all on the falling edge
    initial begin
        bit   prev_req = 0;
        bit   pending = 0;
        int   lat = 0;
        logic [127:0] cap = '0;
        rq_t  e;
        ob_t  o;
        forever begin
            @(negedge clk);
            if (cph_req && !prev_req) begin
                cap = cph_blk;
                if (rq_q.size() == 0) begin
                    chk(0, "R10 unexpected cipher request", cph_blk, '0);
                end else begin
                    e = rq_q.pop_front();
                    chk(cph_ctr == e.tag, {e.lbl, " request kind"}, 128'(cph_ctr), 128'(e.tag));
                    chk(cph_blk == e.blk, {e.lbl, " request block"}, cph_blk, e.blk);
                end
            end
            prev_req = cph_req;
            if (cph_ack) begin
                cph_ack = 1'b0;
            end else if (pending) begin
                lat--;
                if (lat == 0) begin
                    chk(cph_req && cph_blk == cap, "R10 request held until acknowledge", cph_blk, cap);
                    cph_res = stand_in(cph_blk);
                    cph_ack = 1'b1;
                    pending = 0;
                end
            end else if (cph_req) begin
                pending = 1;
                lat = 2;
            end
            if (out_valid) begin
                if (ob_q.size() == 0) begin
                    chk(0, "R8 unexpected output byte", 128'(out_data), '0);
                end else begin
                    o = ob_q.pop_front();
                    chk(out_data == o.data, {o.lbl, " byte"}, 128'(out_data), 128'(o.data));
                    chk(out_last == o.last, {o.lbl, " last marker"}, 128'(out_last), 128'(o.last));
                end
                if (out_last) pkt_done = 1;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    // driver: builds the expected scoreboard items, then streams the packet
    task automatic run_pkt(input logic [2:0] mf, input logic [2:0] lf, input logic [103:0] n,
                           input int alen, input int mlen, input int seed, input bit glitch);
        logic [7:0]   aad[$];
        logic [7:0]   msg[$];
        logic [7:0]   st[$];
        logic [127:0] x, b, a, s;
        int lb, mb, nblk;
        rq_t r;
        ob_t o;
        lb = int'(lf) + 1;
        mb = 2 * int'(mf) + 2;
        for (int i = 0; i < alen; i++) aad.push_back(8'(i * 7 + seed));
        for (int i = 0; i < mlen; i++) msg.push_back(8'(i * 13 + seed * 3 + 1));

        // R2 R3 first block
        b = mk_blk({1'b0, alen > 0, mf, lf}, n, lb, longint'(mlen));
        r.tag = 1'b0; r.blk = b; r.lbl = "R2 R3 first block"; rq_q.push_back(r);
        x = stand_in(b);

        // R4 R5 R6 associated-data blocks
        if (alen > 0) begin
            if (alen < 65280) begin
                st.push_back(8'(alen >> 8)); st.push_back(8'(alen));
            end else begin
                st.push_back(8'hFF); st.push_back(8'hFE);
                for (int k = 3; k >= 0; k--) st.push_back(8'(alen >> (8*k)));
            end
            foreach (aad[i]) st.push_back(aad[i]);
            nblk = (st.size() + 15) / 16;
            for (int j = 0; j < nblk; j++) begin
                b = '0;
                for (int k = 0; k < 16; k++)
                    if (16*j + k < st.size()) b[127-8*k -: 8] = st[16*j + k];
                r.tag = 1'b0; r.blk = x ^ b; r.lbl = "R4 R5 R6 associated-data block";
                rq_q.push_back(r);
                x = stand_in(x ^ b);
            end
        end

        // R7 R5 R6 R8 message blocks
        nblk = (mlen + 15) / 16;
        for (int j = 0; j < nblk; j++) begin
            a = mk_blk({5'b0, lf}, n, lb, longint'(j + 1));
            r.tag = 1'b1; r.blk = a; r.lbl = "R7 counter block"; rq_q.push_back(r);
            s = stand_in(a);
            b = '0;
            for (int k = 0; k < 16; k++)
                if (16*j + k < mlen) b[127-8*k -: 8] = msg[16*j + k];
            r.tag = 1'b0; r.blk = x ^ b; r.lbl = "R5 R6 message MAC block"; rq_q.push_back(r);
            x = stand_in(x ^ b);
            for (int k = 0; k < 16; k++)
                if (16*j + k < mlen) begin
                    o.last = 1'b0; o.data = b[127-8*k -: 8] ^ s[127-8*k -: 8];
                    o.lbl = "R8 ciphertext"; ob_q.push_back(o);
                end
        end

        // R7 R9 tag masking with counter 0
        a = mk_blk({5'b0, lf}, n, lb, 64'd0);
        r.tag = 1'b1; r.blk = a; r.lbl = "R7 R9 counter zero block"; rq_q.push_back(r);
        s = stand_in(a);
        for (int k = 0; k < mb; k++) begin
            o.last = (k == mb - 1); o.data = x[127-8*k -: 8] ^ s[127-8*k -: 8];
            o.lbl = "R9 encrypted tag"; ob_q.push_back(o);
        end

        pkt_done = 0;
        @(negedge clk);
        cfg_mfld = mf; cfg_lfld = lf; cfg_nonce = n; cfg_alen = alen; cfg_mlen = 16'(mlen);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                foreach (aad[i]) send_byte(aad[i]);
                foreach (msg[i]) send_byte(msg[i]);
                @(negedge clk);
                in_valid = 1'b0;
            end
            begin
                if (glitch) begin
                    repeat (20) @(negedge clk);
                    cfg_mfld = ~mf; cfg_lfld = 3'd6; cfg_nonce = ~n; cfg_alen = 0; cfg_mlen = 16'd7;
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
        while (!pkt_done) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(rq_q.size() == 0 && ob_q.size() == 0, "R11 all expected items seen, nothing extra",
            128'(rq_q.size() + ob_q.size()), '0);
        chk(!cph_req && !out_valid && !in_ready, "R1 idle between packets",
            {125'b0, cph_req, out_valid, in_ready}, '0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R1 watchdog act=running exp=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!cph_req && !out_valid && !in_ready && !out_last, "R1 in reset",
            {124'b0, cph_req, out_valid, in_ready, out_last}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!cph_req && !out_valid && !in_ready && !out_last, "R1 after reset",
            {124'b0, cph_req, out_valid, in_ready, out_last}, '0);

        run_pkt(3'd1, 3'd1, 104'h0102030405060708090A0B0C0D, 0, 0, 1, 1'b0);
        run_pkt(3'd3, 3'd2, 104'hA1A2A3A4A5A6A7A8A9AAABACAD, 5, 20, 2, 1'b1);
        run_pkt(3'd7, 3'd7, 104'h1122334455667788990011AABB, 14, 16, 3, 1'b0);
        run_pkt(3'd4, 3'd3, 104'hF0E1D2C3B4A5968778695A4B3C, 40, 33, 4, 1'b0);
        run_pkt(3'd6, 3'd4, 104'h00FF00FF00FF00FF00FF00FF00, 0, 31, 5, 1'b0);
        run_pkt(3'd2, 3'd1, 104'h5A5A5A5A5A5A5A5A5A5A5A5A5A, 65280, 3, 6, 1'b0);
        summary();
    end
endmodule